// File: doc/BRIEF.md
# Four-Level Nested Interrupt Arbiter

This block sits between five interrupt flag sources and a processor core. The sources are two external request lines, two timer overflow flags and one serial-port source; the serial source is pending while either its receive flag or its transmit flag is set. Each source has its own enable bit, and a global enable gates all of them together. Each source also has a two-bit nesting level made of one bit from a high-priority register and one bit from a low-priority register.

The arbiter picks the most urgent enabled pending source. That request goes to the core only when its level is strictly above every handler already in service. When the core acknowledges, the granted level is recorded in a four-bit in-service mask. A return-from-handler pulse retires the highest level in that mask. Each new request comes with a one-cycle wake pulse, which the core uses to leave idle mode.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset, `irq_req`, `irq_wake` and `svc_mask` are 0. The enable, low-level and high-level registers are 0, so pending flags raise no request until software writes the enables.
- R2: While the global enable bit (`en_wdata` bit 5 as last written) is 0, no request is raised, whatever the per-source enables and flags are.
- R3: With the global enable bit set, a pending source is a candidate only if its own enable bit is set (`en_wdata` bits 0..4). The serial source (index 4) is pending when `ser_rx_flag` or `ser_tx_flag` is 1.
- R4: Source i has level {hi bit i, lo bit i}, from 0 (lowest) to 3 (highest). Among candidates, the one with the highest level is chosen, regardless of its polling position.
- R5: Among candidates of equal level, the first in polling order wins. The order is external 0, timer 0, external 1, timer 1, serial. `irq_vec` reports this position as 0 to 4, and `core_flag` bits 0..3 carry the first four sources in that order.
- R6: A request is raised only when no level is in service, or when the candidate's level is strictly above the highest level set in `svc_mask`. A level-3 handler is never preempted.
- R7: Once raised, `irq_req` and `irq_vec` hold steady until `irq_ack` is seen, even across a return pulse. An `irq_ack` while no request is raised has no effect.
- R8: An accepted acknowledge sets `svc_mask` bit L, where L is the granted level. `irq_ret` clears the highest set bit of `svc_mask`.
- R9: `irq_wake` is high for exactly the one cycle in which `irq_req` rises.
- R10: Register writes and `svc_mask` changes take effect on the arbitration decision at the next clock edge. A request therefore appears two edges after the write that enables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_flag | input | 4 | Pending flags: external 0, timer 0, external 1, timer 1 |
| ser_rx_flag | input | 1 | Serial receive flag |
| ser_tx_flag | input | 1 | Serial transmit flag |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 6 | Bits 0..4 per-source enable, bit 5 global enable |
| lo_we | input | 1 | Write strobe for the low level-bit register |
| lo_wdata | input | 5 | Low level bit per source |
| hi_we | input | 1 | Write strobe for the high level-bit register |
| hi_wdata | input | 5 | High level bit per source |
| irq_ack | input | 1 | Core accepts the raised request |
| irq_ret | input | 1 | Core returns from the current handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 3 | Polling position of the requested source |
| irq_wake | output | 1 | One-cycle pulse that clears idle mode |
| svc_mask | output | 4 | In-service levels, bit L for level L |

## Verification
The first pattern drives several sources at the same level, some with their enables off. This separates the polling-order tie-break from source masking, and it separates the OR of the two serial flags from each flag alone. A second pattern mixes levels so that a later-polled level-3 source competes with an earlier-polled level-2 source; this shows that the level outranks the polling position. A third pattern walks nested acknowledge and return sequences. It checks that equal-level requests are held off, that higher levels cut in, and that a level-3 handler stays uninterrupted. It also places a return while a request is raised and an acknowledge while nothing is raised; these tell the hold rule apart from the in-service bookkeeping.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  // Two register bits form a source level, giving four nesting levels.
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_we,
  input  logic [NUM_SRC:0]   en_wdata,
  input  logic               lo_we,
  input  logic [NUM_SRC-1:0] lo_wdata,
  input  logic               hi_we,
  input  logic [NUM_SRC-1:0] hi_wdata,
  output logic               glb_en,
  output logic [NUM_SRC-1:0] src_en,
  output logic [NUM_SRC-1:0] pri_lo,
  output logic [NUM_SRC-1:0] pri_hi
);
  logic [NUM_SRC:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pri_lo <= '0;
      pri_hi <= '0;
    end else begin
      if (en_we) en_q   <= en_wdata;
      if (lo_we) pri_lo <= lo_wdata;
      if (hi_we) pri_hi <= hi_wdata;
    end
  end

  assign glb_en = en_q[NUM_SRC];
  assign src_en = en_q[NUM_SRC-1:0];
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 5,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] cand,
  input  logic [NUM_SRC-1:0] pri_lo,
  input  logic [NUM_SRC-1:0] pri_hi,
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output lvl_t               lvl
);
  lvl_t src_lvl [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
    assign src_lvl[g] = {pri_hi[g], pri_lo[g]};
  end

  // Scan from last to first polling position; ">=" lets an earlier
  // position take over a tie, a strictly higher level always wins.
  always_comb begin
    any = 1'b0;
    idx = '0;
    lvl = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i] && (!any || src_lvl[i] >= lvl)) begin
        any = 1'b1;
        idx = IDX_W'(i);
        lvl = src_lvl[i];
      end
    end
  end
endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track
  import irq_prio_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               grant,
  input  lvl_t               grant_lvl,
  input  logic               ret,
  output logic [NUM_LVL-1:0] svc,
  output logic               cur_any,
  output lvl_t               cur_lvl
);
  logic [NUM_LVL-1:0] top_oh;

  always_comb begin
    top_oh  = '0;
    cur_lvl = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (svc[i]) begin
        top_oh  = NUM_LVL'(1) << i;
        cur_lvl = lvl_t'(i);
      end
    end
  end

  assign cur_any = |svc;

  always_ff @(posedge clk) begin
    if (rst) svc <= '0;
    else     svc <= (svc & ~(ret ? top_oh : '0))
                  | (grant ? (NUM_LVL'(1) << grant_lvl) : '0);
  end

  // R8: a grant adds one in-service level (always above the current top)
  p_grant_adds_r8: assert property (@(posedge clk) disable iff (rst)
    grant && !ret |=> $countones(svc) == $countones($past(svc)) + 1);

  // R8: a return retires exactly one level
  p_ret_drops_r8: assert property (@(posedge clk) disable iff (rst)
    ret && !grant && cur_any |=> $countones(svc) + 1 == $countones($past(svc)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 5,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-2:0] core_flag,
  input  logic               ser_rx_flag,
  input  logic               ser_tx_flag,
  input  logic               en_we,
  input  logic [NUM_SRC:0]   en_wdata,
  input  logic               lo_we,
  input  logic [NUM_SRC-1:0] lo_wdata,
  input  logic               hi_we,
  input  logic [NUM_SRC-1:0] hi_wdata,
  input  logic               irq_ack,
  input  logic               irq_ret,
  output logic               irq_req,
  output logic [IDX_W-1:0]   irq_vec,
  output logic               irq_wake,
  output logic [NUM_LVL-1:0] svc_mask
);
  logic               glb_en;
  logic [NUM_SRC-1:0] src_en, pri_lo, pri_hi, cand;
  logic               best_any, cur_any, eligible, grant;
  logic [IDX_W-1:0]   best_idx;
  lvl_t               best_lvl, cur_lvl, lvl_q;

  irq_cfg_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst(rst),
    .en_we(en_we), .en_wdata(en_wdata),
    .lo_we(lo_we), .lo_wdata(lo_wdata),
    .hi_we(hi_we), .hi_wdata(hi_wdata),
    .glb_en(glb_en), .src_en(src_en), .pri_lo(pri_lo), .pri_hi(pri_hi)
  );

  // Serial source sits last in polling order and merges its two flags.
  assign cand = {ser_rx_flag | ser_tx_flag, core_flag} & src_en & {NUM_SRC{glb_en}};

  irq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .cand(cand), .pri_lo(pri_lo), .pri_hi(pri_hi),
    .any(best_any), .idx(best_idx), .lvl(best_lvl)
  );

  assign grant = irq_ack & irq_req;

  irq_nest_track u_nest (
    .clk(clk), .rst(rst),
    .grant(grant), .grant_lvl(lvl_q), .ret(irq_ret),
    .svc(svc_mask), .cur_any(cur_any), .cur_lvl(cur_lvl)
  );

  assign eligible = best_any && (!cur_any || best_lvl > cur_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      irq_vec  <= '0;
      lvl_q    <= '0;
      irq_wake <= 1'b0;
    end else begin
      irq_wake <= 1'b0;
      if (irq_req) begin
        if (irq_ack) irq_req <= 1'b0;
      end else if (eligible) begin
        irq_req  <= 1'b1;
        irq_vec  <= best_idx;
        lvl_q    <= best_lvl;
        irq_wake <= 1'b1;
      end
    end
  end

  // R7: request and vector hold until acknowledged
  p_vec_hold_r7: assert property (@(posedge clk) disable iff (rst)
    irq_req && !irq_ack |=> irq_req && $stable(irq_vec));

  // R9: wake marks exactly the rising cycle of the request
  p_wake_on_rise_r9: assert property (@(posedge clk) disable iff (rst)
    irq_wake |-> irq_req && !$past(irq_req));
  p_rise_has_wake_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> irq_wake);

  // R6: a new request is strictly above every in-service level
  p_preempt_strict_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) && cur_any |-> lvl_q > cur_lvl);

  // R2: no request rises unless the global enable was set
  p_global_gate_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(glb_en));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] core_flag = '0;
  logic       ser_rx_flag = 1'b0, ser_tx_flag = 1'b0;
  logic       en_we = 1'b0, lo_we = 1'b0, hi_we = 1'b0;
  logic [5:0] en_wdata = '0;
  logic [4:0] lo_wdata = '0, hi_wdata = '0;
  logic       irq_ack = 1'b0, irq_ret = 1'b0;
  logic       irq_req, irq_wake;
  logic [2:0] irq_vec;
  logic [3:0] svc_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic       req;
    logic [2:0] vec;
    bit         vcare;
    logic [3:0] svc;
    logic       wake;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst(rst),
    .core_flag(core_flag), .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
    .en_we(en_we), .en_wdata(en_wdata),
    .lo_we(lo_we), .lo_wdata(lo_wdata),
    .hi_we(hi_we), .hi_wdata(hi_wdata),
    .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_wake(irq_wake), .svc_mask(svc_mask)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Driver: push the state expected right after the coming edge,
  // then advance to the next falling edge and drop the strobes.
  task automatic step(logic e_req, logic [2:0] e_vec, bit vcare,
                      logic [3:0] e_svc, logic e_wake, string tag);
    exp_t e;
    e.req = e_req; e.vec = e_vec; e.vcare = vcare;
    e.svc = e_svc; e.wake = e_wake; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    en_we = 1'b0; lo_we = 1'b0; hi_we = 1'b0;
    irq_ack = 1'b0; irq_ret = 1'b0;
  endtask

  // Monitor: compare just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (irq_req !== e.req || (e.vcare && irq_vec !== e.vec) ||
            svc_mask !== e.svc || irq_wake !== e.wake) begin
          fails++;
          $display("FAIL %s: got req=%b vec=%0d svc=%b wake=%b, expected req=%b vec=%0d svc=%b wake=%b",
                   e.tag, irq_req, irq_vec, svc_mask, irq_wake,
                   e.req, e.vec, e.svc, e.wake);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    step(0, 0, 0, 4'b0000, 0, "R1 idle after reset");

    // R2: enables set but global bit off
    core_flag = 4'b1111; ser_rx_flag = 1'b1;
    en_wdata = 6'b0_11111; en_we = 1'b1;
    step(0, 0, 0, 4'b0000, 0, "R2 global off");
    step(0, 0, 0, 4'b0000, 0, "R2 global off masks");
    step(0, 0, 0, 4'b0000, 0, "R2 global off masks");

    // R3/R5: only ext1 and serial enabled, both level 0
    en_wdata = 6'b1_10100; en_we = 1'b1;
    step(0, 0, 0, 4'b0000, 0, "R10 write not yet seen");
    step(1, 2, 1, 4'b0000, 1, "R5 ext1 beats serial at equal level");
    step(1, 2, 1, 4'b0000, 0, "R7 held, R9 single pulse");
    irq_ack = 1'b1;
    step(0, 0, 0, 4'b0001, 0, "R8 ack sets level 0");
    step(0, 0, 0, 4'b0001, 0, "R6 equal level does not preempt");

    // R4/R6: serial to level 1
    lo_wdata = 5'b10000; lo_we = 1'b1;
    step(0, 0, 0, 4'b0001, 0, "R10 level write not yet seen");
    step(1, 4, 1, 4'b0001, 1, "R6 serial level 1 preempts level 0");
    irq_ack = 1'b1;
    step(0, 0, 0, 4'b0011, 0, "R8 ack sets level 1");

    // ext0 -> level 2 (disabled), tmr1 -> level 3
    hi_wdata = 5'b01001; hi_we = 1'b1;
    step(0, 0, 0, 4'b0011, 0, "R3 disabled sources ignored");
    lo_wdata = 5'b11000; lo_we = 1'b1;
    step(0, 0, 0, 4'b0011, 0, "R3 disabled sources ignored");
    en_wdata = 6'b1_11111; en_we = 1'b1;
    step(0, 0, 0, 4'b0011, 0, "R10 enable write not yet seen");
    step(1, 3, 1, 4'b0011, 1, "R4 level 3 tmr1 beats earlier ext0 level 2");
    irq_ack = 1'b1;
    step(0, 0, 0, 4'b1011, 0, "R8 ack sets level 3");
    step(0, 0, 0, 4'b1011, 0, "R6 level 3 not preempted");
    step(0, 0, 0, 4'b1011, 0, "R6 level 3 not preempted");

    core_flag = 4'b0101;
    irq_ack = 1'b1;
    step(0, 0, 0, 4'b1011, 0, "R7 ack without request ignored");
    irq_ret = 1'b1;
    step(0, 0, 0, 4'b0011, 0, "R8 return clears level 3");
    step(1, 0, 1, 4'b0011, 1, "R6 ext0 level 2 preempts level 1");
    irq_ret = 1'b1;
    step(1, 0, 1, 4'b0001, 0, "R7 request held across return");
    irq_ack = 1'b1;
    step(0, 0, 0, 4'b0101, 0, "R8 ack sets level 2");
    irq_ret = 1'b1;
    step(0, 0, 0, 4'b0001, 0, "R8 return clears level 2");
    irq_ret = 1'b1;
    step(1, 0, 1, 4'b0000, 1, "R8 return clears level 0, R6 ext0 re-requests");

    // R1: mid-run reset clears state and registers
    rst = 1'b1;
    step(0, 0, 0, 4'b0000, 0, "R1 reset clears outputs");
    rst = 1'b0;
    step(0, 0, 0, 4'b0000, 0, "R1 enables cleared by reset");
    step(0, 0, 0, 4'b0000, 0, "R1 enables cleared by reset");

    // R3: serial via transmit flag only, ext0 pending but disabled
    core_flag = 4'b0001; ser_rx_flag = 1'b0; ser_tx_flag = 1'b1;
    en_wdata = 6'b1_10000; en_we = 1'b1;
    step(0, 0, 0, 4'b0000, 0, "R10 write not yet seen");
    step(1, 4, 1, 4'b0000, 1, "R3 tx flag requests serial, ext0 disabled");

    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule